// File: doc/BRIEF.md
# Atomic GPIO Output Register Bank

This block keeps the drive level and the direction of up to 64 pins, split into a low word (pins 0 to 31) and a high word (pins 32 and up). Each stored word can be changed through four write views: a plain overwrite, an OR-in of a mask, a clear of a mask and an invert of a mask. Because the set, clear and invert views only touch the bits that are 1 in the written mask, several agents can change their own pins without reading the word first. A masked put, which forces the bits under a mask to given values, is done by writing `(current ^ value) & mask` to the invert view.

The same bus also reads back the stored level and direction words and the pin levels after a two-flop synchroniser. The bus is a plain single-cycle register port. A write takes effect at the clock edge that accepts it. Read data is registered and appears one cycle after the read strobe.

Top module: `gpio_atomic_bank`

## Requirements
- R1: While `rst_n` is low, every level and direction bit is 0, so every pin is an input, and `bus_rdata` is 0.
- R2: The word address is `bus_addr = {group[1:0], view[1:0], half}`. Group 1 is the level word and group 2 the direction word. A write with view 0 replaces the addressed word with `bus_wdata`.
- R3: A write with view 1 sets to 1 every bit that is 1 in `bus_wdata` and leaves the other bits of the word unchanged.
- R4: A write with view 2 clears to 0 every bit that is 1 in `bus_wdata` and leaves the other bits of the word unchanged.
- R5: A write with view 3 inverts every bit that is 1 in `bus_wdata`. Writing `(current ^ value) & mask` there makes the bits under `mask` equal to `value` and leaves the rest unchanged.
- R6: The direction word (group 2) has the same four views. `pin_oe[i]` = 1 means pin i drives `pin_out[i]`, and 0 means pin i is an input.
- R7: `half` = 0 addresses pins 0..31 and `half` = 1 addresses pins 32..NUM_PINS-1. High-word bits for pins that do not exist read as 0 and ignore writes.
- R8: A read of group 0 (any view) returns the pin levels of the addressed half after two-flop synchronisation. A level applied before clock edge k is returned by a read strobed at edge k+2.
- R9: A read of group 1 or 2 (any view) returns the stored word of the addressed half in the next cycle and changes no state. When no read is strobed, `bus_rdata` returns to 0.
- R10: Writes to group 0 or group 3 change nothing, and reads of group 3 return 0.
- R11: A write changes `pin_out`/`pin_oe` at the clock edge that accepts it. Without a write, both stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, accepted at the rising edge |
| bus_rd | input | 1 | Read strobe, data registered at the rising edge |
| bus_addr | input | 5 | `{group, view, half}` word address |
| bus_wdata | input | 32 | Write data or mask |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS | Raw pin levels |
| pin_out | output | NUM_PINS | Stored drive levels |
| pin_oe | output | NUM_PINS | Stored direction bits, 1 = output |

## Verification
The hardest case to reach from the ports is a view write landing on a word whose bits already hold a mix of ones and zeros, with a mask that covers only part of it. Only then is a broken "leave the others alone" rule visible. The bench therefore reloads each word with a mixed seed through the overwrite view before every set, clear and invert write, and sweeps four different masks across both halves of both words. The bits above the last pin are also hard to see, because no pin carries them. The bench exposes them by writing all-ones masks to the high half and reading the word back.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    VW_WRITE  = 2'd0,
    VW_SET    = 2'd1,
    VW_CLEAR  = 2'd2,
    VW_TOGGLE = 2'd3
  } view_e;

  typedef enum logic [1:0] {
    GRP_INPUT = 2'd0,
    GRP_LEVEL = 2'd1,
    GRP_DIR   = 2'd2,
    GRP_NONE  = 2'd3
  } group_e;

  // New word value produced by one write through a given view.
  function automatic logic [WORD_W-1:0] apply_view(view_e v,
                                                   logic [WORD_W-1:0] cur,
                                                   logic [WORD_W-1:0] arg);
    logic [WORD_W-1:0] r;
    case (v)
      VW_WRITE:  r = arg;
      VW_SET:    r = cur | arg;
      VW_CLEAR:  r = cur & ~arg;
      default:   r = cur ^ arg;
    endcase
    return r;
  endfunction

  // Bits of a half-word that correspond to existing pins.
  function automatic logic [WORD_W-1:0] half_mask(int unsigned num_pins,
                                                  int unsigned half);
    logic [WORD_W-1:0] m;
    for (int unsigned i = 0; i < WORD_W; i++) begin
      m[i] = ((half * WORD_W + i) < num_pins);
    end
    return m;
  endfunction

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int unsigned W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] synced
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      synced <= '0;
    end else begin
      stage1 <= raw;
      synced <= stage1;
    end
  end
endmodule

// File: rtl/gpio_bank_word.sv
module gpio_bank_word
  import gpio_bank_pkg::*;
#(
  parameter logic [WORD_W-1:0] VALID = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  view_e             view,
  input  logic [WORD_W-1:0] arg,
  output logic [WORD_W-1:0] q
);
  logic [WORD_W-1:0] nxt;

  assign nxt = apply_view(view, q, arg) & VALID;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (wr_en) q <= nxt;
  end
endmodule

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
  import gpio_bank_pkg::*;
(
  input  logic       bus_wr,
  input  logic [4:0] bus_addr,
  output logic [3:0] wr_hit,
  output view_e      wr_view,
  output group_e     sel_group,
  output logic       sel_half
);
  assign sel_group = group_e'(bus_addr[4:3]);
  assign wr_view   = view_e'(bus_addr[2:1]);
  assign sel_half  = bus_addr[0];

  // wr_hit index = {is_direction, half}
  always_comb begin
    wr_hit = '0;
    if (bus_wr && (sel_group == GRP_LEVEL || sel_group == GRP_DIR)) begin
      wr_hit[{sel_group == GRP_DIR, sel_half}] = 1'b1;
    end
  end
endmodule

// File: rtl/gpio_atomic_bank.sv
module gpio_atomic_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 40
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [4:0]          bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);
  localparam int unsigned HI_W = NUM_PINS - WORD_W;

  initial begin
    if (NUM_PINS <= WORD_W || NUM_PINS > 2 * WORD_W)
      $error("NUM_PINS must lie in 33..64");
  end

  logic [3:0]               wr_hit;
  view_e                    wr_view;
  group_e                   sel_group;
  logic                     sel_half;
  logic [NUM_PINS-1:0]      pin_in_sync;
  logic [3:0][WORD_W-1:0]   stored_word;
  logic [1:0][WORD_W-1:0]   in_word;
  logic [WORD_W-1:0]        rd_value;

  gpio_bank_decode dec_i (
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .wr_hit   (wr_hit),
    .wr_view  (wr_view),
    .sel_group(sel_group),
    .sel_half (sel_half)
  );

  gpio_bank_sync #(.W(NUM_PINS)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   (pin_in),
    .synced(pin_in_sync)
  );

  for (genvar g = 0; g < 2; g++) begin : g_group
    for (genvar h = 0; h < 2; h++) begin : g_half
      localparam int unsigned W = (h == 0) ? WORD_W : HI_W;
      gpio_bank_word #(.VALID(half_mask(NUM_PINS, h))) word_i (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(wr_hit[g*2+h]),
        .view (wr_view),
        .arg  (bus_wdata),
        .q    (stored_word[g*2+h])
      );
      if (g == 0) begin : g_lvl
        assign pin_out[h*WORD_W +: W] = stored_word[g*2+h][W-1:0];
      end else begin : g_dir
        assign pin_oe[h*WORD_W +: W] = stored_word[g*2+h][W-1:0];
      end
    end
  end

  assign in_word[0] = pin_in_sync[WORD_W-1:0];
  assign in_word[1] = WORD_W'(pin_in_sync[NUM_PINS-1:WORD_W]);

  always_comb begin
    case (sel_group)
      GRP_INPUT: rd_value = in_word[sel_half];
      GRP_LEVEL: rd_value = stored_word[{1'b0, sel_half}];
      GRP_DIR:   rd_value = stored_word[{1'b1, sel_half}];
      default:   rd_value = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= bus_rd ? rd_value : '0;
  end
endmodule

// File: rtl/gpio_atomic_bank_chk.sv
module gpio_atomic_bank_chk #(
  parameter int unsigned NUM_PINS = 40
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [4:0]          bus_addr,
  input logic [31:0]         bus_wdata,
  input logic [31:0]         bus_rdata,
  input logic [NUM_PINS-1:0] pin_in,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NUM_PINS-1:0] pin_in_sync,
  input logic [3:0]          wr_hit
);
  logic [1:0] since_rst;
  logic       lvl_lo_wr;
  logic       dir_lo_wr;
  logic       dead_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  assign lvl_lo_wr = bus_wr && bus_addr[4:3] == 2'd1 && !bus_addr[0];
  assign dir_lo_wr = bus_wr && bus_addr[4:3] == 2'd2 && !bus_addr[0];
  assign dead_wr   = bus_wr && (bus_addr[4:3] == 2'd0 || bus_addr[4:3] == 2'd3);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (pin_out == '0 && pin_oe == '0 && bus_rdata == '0));

  p_one_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));

  p_set_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_lo_wr && bus_addr[2:1] == 2'd1 |=>
      ((pin_out[31:0] & $past(bus_wdata)) == $past(bus_wdata)) &&
      ((pin_out[31:0] & ~$past(bus_wdata)) == ($past(pin_out[31:0]) & ~$past(bus_wdata))));

  p_clear_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_lo_wr && bus_addr[2:1] == 2'd2 |=>
      ((pin_out[31:0] & $past(bus_wdata)) == '0) &&
      ((pin_out[31:0] | $past(bus_wdata)) == ($past(pin_out[31:0]) | $past(bus_wdata))));

  p_toggle_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_lo_wr && bus_addr[2:1] == 2'd3 |=>
      pin_out[31:0] == ($past(pin_out[31:0]) ^ $past(bus_wdata)));

  p_dir_write_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dir_lo_wr && bus_addr[2:1] == 2'd0 |=> pin_oe[31:0] == $past(bus_wdata));

  p_hi_spare_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr[4:3] != 2'd3 && bus_addr[0] |=>
      (64'(bus_rdata) >> (NUM_PINS - 32)) == 64'd0);

  p_sync_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    since_rst == 2'd2 |-> pin_in_sync == $past(pin_in, 2));

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == '0);

  p_dead_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dead_wr |=> $stable(pin_out) && $stable(pin_oe));

  p_dead_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr[4:3] == 2'd3 |=> bus_rdata == '0);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(pin_out) && $stable(pin_oe));
endmodule

bind gpio_atomic_bank gpio_atomic_bank_chk #(.NUM_PINS(NUM_PINS)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .pin_in     (pin_in),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe),
  .pin_in_sync(pin_in_sync),
  .wr_hit     (wr_hit)
);

// File: tb/gpio_atomic_bank_tb_top.sv
module gpio_atomic_bank_tb_top;
  localparam int unsigned NP = 40;
  localparam logic [63:0] PIN_MASK = (64'd1 << NP) - 64'd1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [4:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [63:0] ref_lvl = '0;
  logic [63:0] ref_dir = '0;

  always #10 clk = ~clk;

  gpio_atomic_bank #(.NUM_PINS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] adr(int grp, int view, int half);
    return 5'(grp * 8 + view * 2 + half);
  endfunction

  // Model of one write, restated bit by bit from R2..R7.
  task automatic model_write(int grp, int view, int half, logic [31:0] d);
    logic [63:0] cur;
    logic [63:0] wide;
    cur  = (grp == 1) ? ref_lvl : ref_dir;
    wide = (half == 1) ? {d, 32'd0} : {32'd0, d};
    for (int b = 0; b < 64; b++) begin
      if ((b >= 32) == (half == 1)) begin
        if (view == 0)      cur[b] = wide[b];
        else if (wide[b]) begin
          if (view == 1)      cur[b] = 1'b1;
          else if (view == 2) cur[b] = 1'b0;
          else                cur[b] = !cur[b];
        end
      end
    end
    cur = cur & PIN_MASK;
    if (grp == 1) ref_lvl = cur;
    else if (grp == 2) ref_dir = cur;
  endtask

  task automatic do_write(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    model_write(int'(a[4:3]), int'(a[2:1]), int'(a[0]), d);
  endtask

  task automatic do_read(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] half_of(logic [63:0] v, int half);
    return half ? v[63:32] : v[31:0];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] seed;
    logic [31:0] pat;
    logic [63:0] lvl_before;
    logic [63:0] dir_before;
    logic [63:0] pv;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 pin_out in reset", 64'(pin_out), 64'd0);
    check("R1 pin_oe in reset", 64'(pin_oe), 64'd0);
    check("R1 rdata in reset", 64'(bus_rdata), 64'd0);
    rst_n = 1'b1;
    do_read(adr(1, 0, 0), rd); check("R1 level lo after reset", 64'(rd), 64'd0);
    do_read(adr(2, 0, 1), rd); check("R1 dir hi after reset", 64'(rd), 64'd0);

    // R2..R7, R11: sweep of groups, halves, views and masks
    for (int g = 1; g <= 2; g++) begin
      for (int h = 0; h < 2; h++) begin
        for (int v = 0; v < 4; v++) begin
          for (int k = 0; k < 4; k++) begin
            seed = 32'h6C3A_95F0 ^ (32'h1111_1111 * 32'(k + v));
            pat  = {32'hF0F0_5A5A} >> k | (32'h0000_0101 << (3 * v + h));
            do_write(adr(g, 0, h), seed);
            do_write(adr(g, v, h), pat);
            // R11: visible on the pins right after the accepting edge
            check($sformatf("R11 g%0d h%0d v%0d pin_out", g, h, v),
                  64'(pin_out), ref_lvl);
            check($sformatf("R6 g%0d h%0d v%0d pin_oe", g, h, v),
                  64'(pin_oe), ref_dir);
            do_read(adr(g, v, h), rd);
            check($sformatf("R%0d readback g%0d h%0d", v + 2, g, h),
                  64'(rd), 64'(half_of(g == 1 ? ref_lvl : ref_dir, h)));
          end
        end
      end
    end

    // R7: spare high bits
    do_write(adr(1, 0, 1), 32'hFFFF_FFFF);
    do_read(adr(1, 0, 1), rd);
    check("R7 level hi spare bits", 64'(rd), 64'h0000_00FF);
    do_write(adr(2, 3, 1), 32'hFFFF_FFFF);
    do_read(adr(2, 2, 1), rd);
    check("R7 dir hi spare bits", 64'(rd), 64'(half_of(ref_dir, 1)));
    check("R7 pins 32..39 driven", 64'(pin_out[39:32]), 64'hFF);

    // R5: masked put through the invert view
    do_write(adr(1, 0, 0), 32'h1234_5678);
    do_read(adr(1, 0, 0), rd);
    do_write(adr(1, 3, 0), (rd ^ 32'hABCD_EF01) & 32'h00FF_FF00);
    check("R5 masked put", 64'(pin_out[31:0]),
          64'((32'h1234_5678 & ~32'h00FF_FF00) | (32'hABCD_EF01 & 32'h00FF_FF00)));

    // R8: synchronised input view
    for (int k = 0; k < 4; k++) begin
      pv = (64'hC3A5_9617_0F1E_2D3C * 64'(k + 1)) & PIN_MASK;
      @(negedge clk);
      pin_in = pv[NP-1:0];
      @(posedge clk); @(posedge clk);
      do_read(adr(0, k, 0), rd);
      check("R8 input lo", 64'(rd), 64'(pv[31:0]));
      do_read(adr(0, 3 - k, 1), rd);
      check("R8 input hi", 64'(rd), 64'(pv[63:32]));
    end

    // R9: reads change nothing, rdata idles at zero
    lvl_before = ref_lvl; dir_before = ref_dir;
    do_read(adr(1, 1, 0), rd);
    do_read(adr(2, 2, 1), rd);
    check("R9 level after reads", 64'(pin_out), lvl_before);
    check("R9 dir after reads", 64'(pin_oe), dir_before);
    @(negedge clk);
    check("R9 rdata idle", 64'(bus_rdata), 64'd0);

    // R10: dead groups
    do_write(adr(3, 1, 0), 32'hFFFF_FFFF);
    do_write(adr(0, 0, 1), 32'hFFFF_FFFF);
    do_write(adr(3, 2, 1), 32'hFFFF_FFFF);
    check("R10 level after dead writes", 64'(pin_out), lvl_before);
    check("R10 dir after dead writes", 64'(pin_oe), dir_before);
    do_read(adr(3, 0, 0), rd);
    check("R10 dead read", 64'(rd), 64'd0);

    // R1: reset again clears everything
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 level after reset", 64'(pin_out), 64'd0);
    check("R1 dir after reset", 64'(pin_oe), 64'd0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule